// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block turns one fast source clock into three families of gated clock outputs for power management. There are four CPU-rate outputs, eight SDRAM-rate outputs at the same rate, and seven PCI outputs at half that rate. A toggle divider produces the PCI rate and runs without pause, so the PCI phase keeps its relation to the CPU clock across every stop. One PCI output is always free-running.

Two of the eight SDRAM pins are shared. When the mode input is low they stop driving and become the CPU-stop and PCI-stop request inputs. When mode is high they carry SDRAM clocks, and both stop requests count as released. Each request passes through a two-flop synchronizer in the clock domain it gates. The enable register for each group changes only on the falling edge of that group's clock, so an output never shows a shortened high phase. The power-down input clears every enable at once, without waiting for a clock edge. Outputs come back through the same synchronizers once power-down is released.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While pwr_dn_i is high, every clock output (cpu_clk_o, pci_clk_o, sdram_clk_o, and the shared pins when mode_i is high) is low. A rising pwr_dn_i forces them low at once, even in the middle of a high phase.
- R2: After pwr_dn_i falls, the first high pulse on the CPU and SDRAM outputs starts on the third rising edge of clk_i. In the first ten edges, counting from the one after release, exactly eight pulses appear.
- R3: When no stop is active, all four cpu_clk_o bits and all eight SDRAM outputs give one rising edge per clk_i period.
- R4: Every pci_clk_o bit gives one rising edge per two clk_i periods.
- R5: With mode_i low, sdram_pin_io is high-impedance. Bit 0 is the active-high CPU-stop request and bit 1 is the active-high PCI-stop request.
- R6: A CPU stop lets exactly two more CPU pulses out (the edges at which the request is first and second seen), then holds all cpu_clk_o low. After the request is removed, pulses restart on the third rising edge of clk_i.
- R7: A PCI stop holds pci_clk_o[6:1] low. pci_clk_o[0] keeps running at half rate. CPU and SDRAM outputs are not affected.
- R8: With mode_i high, any stop that was in force is released. All eight SDRAM outputs, including sdram_pin_io[1:0], toggle at the clk_i rate.
- R9: Every high phase on a gated output has full width: half a clk_i period on CPU and SDRAM outputs, and one clk_i period on PCI outputs.
- R10: After a PCI stop ends, each rising edge of the gated PCI outputs lines up with a rising edge of the free-running pci_clk_o[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock at the CPU rate |
| pwr_dn_i | input | 1 | Power-down; high forces all outputs low at once |
| mode_i | input | 1 | High: shared pins are SDRAM clocks; low: shared pins are stop inputs |
| cpu_clk_o | output | 4 | CPU-rate gated clocks |
| pci_clk_o | output | 7 | Half-rate clocks; bit 0 free-running |
| sdram_clk_o | output | 6 | Dedicated SDRAM-rate clocks |
| sdram_pin_io | inout | 2 | Shared pins: SDRAM clocks, or bit 0 CPU stop and bit 1 PCI stop |

## Verification
The assertions assume the following about the inputs:
- clk_i runs continuously.
- pwr_dn_i, once raised, stays high for several source cycles.
- mode_i and both stop requests stay steady for at least three cycles of the domain they gate.
- The source of the shared pins releases them whenever mode_i is high.

The stimulus meets these assumptions:
- Every input change happens shortly after a falling edge of clk_i, and each level is then held for ten or more cycles.
- The stop pins are driven only while mode_i is low, from the same mode signal the block sees, so the two sides never drive a pin at the same time.
- Power-down is held for twenty cycles.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  localparam int CPU_OUTS         = 4;
  localparam int PCI_OUTS         = 7;
  localparam int SDRAM_FIXED_OUTS = 6;
  localparam int SHARED_PINS      = 2;
  localparam int SYNC_DEPTH       = 2;
  localparam int FREE_PCI_IDX     = 0;
  localparam int PIN_CPU_STOP     = 0;
  localparam int PIN_PCI_STOP     = 1;
endpackage

// File: rtl/clk_half_div.sv
`timescale 1ns/1ps
module clk_half_div (
  input  logic clk_i,
  input  logic pwr_dn_i,
  output logic half_o
);
  // Toggle divider; ignores clock stops so PCI phase is kept.
  always_ff @(posedge clk_i or posedge pwr_dn_i) begin
    if (pwr_dn_i) half_o <= 1'b0;
    else          half_o <= ~half_o;
  end
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic pwr_dn_i,
  input  logic run_i,
  output logic en_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;

  // Synchronizer in the gated domain; cleared by power-down.
  always_ff @(posedge clk_i or posedge pwr_dn_i) begin
    if (pwr_dn_i) sync_q <= '0;
    else          sync_q <= {sync_q[MSB-1:0], run_i};
  end

  // Enable only moves while the clock is low.
  always_ff @(negedge clk_i or posedge pwr_dn_i) begin
    if (pwr_dn_i) en_o <= 1'b0;
    else          en_o <= sync_q[MSB];
  end
endmodule

// File: rtl/stop_pin_mux.sv
`timescale 1ns/1ps
module stop_pin_mux
  import clk_stop_pkg::*;
(
  input  logic                   mode_i,
  input  logic [SHARED_PINS-1:0] pin_clk_i,
  inout  wire  [SHARED_PINS-1:0] pin_io,
  output logic                   cpu_stop_o,
  output logic                   pci_stop_o
);
  // Drive clocks in mode high, float and listen in mode low.
  assign pin_io     = mode_i ? pin_clk_i : {SHARED_PINS{1'bz}};
  assign cpu_stop_o = ~mode_i & pin_io[PIN_CPU_STOP];
  assign pci_stop_o = ~mode_i & pin_io[PIN_PCI_STOP];
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int N_CPU       = CPU_OUTS,
  parameter int N_PCI       = PCI_OUTS,
  parameter int N_SDR       = SDRAM_FIXED_OUTS,
  parameter int SYNC_STAGES = SYNC_DEPTH,
  parameter int FREE_PCI    = FREE_PCI_IDX
) (
  input  logic                   clk_i,
  input  logic                   pwr_dn_i,
  input  logic                   mode_i,
  output logic [N_CPU-1:0]       cpu_clk_o,
  output logic [N_PCI-1:0]       pci_clk_o,
  output logic [N_SDR-1:0]       sdram_clk_o,
  inout  wire  [SHARED_PINS-1:0] sdram_pin_io
);
  logic pci_src;
  logic cpu_stop, pci_stop;
  logic cpu_en, sdr_en, pci_en, pci_free_en;
  logic [SHARED_PINS-1:0] pin_clk;

  clk_half_div u_div (
    .clk_i    (clk_i),
    .pwr_dn_i (pwr_dn_i),
    .half_o   (pci_src)
  );

  stop_pin_mux u_mux (
    .mode_i     (mode_i),
    .pin_clk_i  (pin_clk),
    .pin_io     (sdram_pin_io),
    .cpu_stop_o (cpu_stop),
    .pci_stop_o (pci_stop)
  );

  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_gate (
    .clk_i (clk_i), .pwr_dn_i (pwr_dn_i), .run_i (~cpu_stop), .en_o (cpu_en)
  );
  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_sdr_gate (
    .clk_i (clk_i), .pwr_dn_i (pwr_dn_i), .run_i (1'b1), .en_o (sdr_en)
  );
  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pci_gate (
    .clk_i (pci_src), .pwr_dn_i (pwr_dn_i), .run_i (~pci_stop), .en_o (pci_en)
  );
  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pcf_gate (
    .clk_i (pci_src), .pwr_dn_i (pwr_dn_i), .run_i (1'b1), .en_o (pci_free_en)
  );

  assign pin_clk = {SHARED_PINS{clk_i & sdr_en}};

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    assign cpu_clk_o[g] = clk_i & cpu_en;
  end

  for (genvar g = 0; g < N_SDR; g++) begin : g_sdr
    assign sdram_clk_o[g] = clk_i & sdr_en;
  end

  for (genvar g = 0; g < N_PCI; g++) begin : g_pci
    if (g == FREE_PCI) begin : g_free
      assign pci_clk_o[g] = pci_src & pci_free_en;
    end else begin : g_stoppable
      assign pci_clk_o[g] = pci_src & pci_en;
    end
  end

  AST_PWR_DOWN_LOW: assert property (@(negedge clk_i)
    pwr_dn_i |-> (cpu_clk_o == '0 && pci_clk_o == '0 && sdram_clk_o == '0)); // R1

  AST_CPU_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (pwr_dn_i)
    (cpu_stop && $past(cpu_stop) && $past(cpu_stop, 2)) |-> !cpu_en); // R6

  AST_PCI_STOP_HOLDS: assert property (@(posedge pci_src) disable iff (pwr_dn_i)
    (pci_stop && $past(pci_stop) && $past(pci_stop, 2)) |-> !pci_en); // R7

  AST_FREE_PCI_KEEPS: assert property (@(posedge clk_i) disable iff (pwr_dn_i)
    pci_free_en |=> pci_free_en); // R7

  AST_MODE_HIGH_RUNS: assert property (@(posedge clk_i) disable iff (pwr_dn_i)
    (mode_i && $past(mode_i) && $past(mode_i, 2) && !$past(pwr_dn_i, 2))
    |-> (cpu_en && sdr_en)); // R8
endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NSIG       = 19;

  logic clk = 1'b0;
  logic pwr_dn = 1'b0;
  logic mode = 1'b1;
  logic cpu_stop_drv = 1'b0;
  logic pci_stop_drv = 1'b0;
  logic [3:0] cpu_clk;
  logic [6:0] pci_clk;
  logic [5:0] sdram_clk;
  wire  [1:0] pins;

  assign pins = mode ? 2'bzz : {pci_stop_drv, cpu_stop_drv};

  clk_stop_ctrl dut_i (
    .clk_i        (clk),
    .pwr_dn_i     (pwr_dn),
    .mode_i       (mode),
    .cpu_clk_o    (cpu_clk),
    .pci_clk_o    (pci_clk),
    .sdram_clk_o  (sdram_clk),
    .sdram_pin_io (pins)
  );

  initial forever #(HALF) clk = ~clk;

  // bit map: cpu 0-3, pci 4-10, sdram 11-16, shared pins 17-18
  wire [NSIG-1:0] vec = {pins, sdram_clk, pci_clk, cpu_clk};

  int checks = 0;
  int errors = 0;
  int cnt [NSIG];
  logic [NSIG-1:0] last = '0;
  int phase_err = 0;
  int width_err = 0;
  bit mon = 1'b0;
  bit done = 1'b0;
  time rise_cpu, rise_pci;

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NSIG; i++)
      if (vec[i] === 1'b1 && last[i] !== 1'b1) cnt[i]++;
    if (pci_clk[1] === 1'b1 && pci_clk[0] !== 1'b1) phase_err++;
    last = vec;
  end

  always @(negedge clk) begin
    #1;
    last = vec;
  end

  always @(posedge cpu_clk[0]) rise_cpu = $time;
  always @(negedge cpu_clk[0]) if (mon && ($time - rise_cpu) != HALF) width_err++;
  always @(posedge pci_clk[1]) rise_pci = $time;
  always @(negedge pci_clk[1]) if (mon && ($time - rise_pci) != CLK_PERIOD) width_err++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NSIG; i++) cnt[i] = 0;
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    pwr_dn = 1'b1;
    cyc(2);
    clear_counts();
    cyc(20);
    check_eq("R1", "outputs in power-down", int'(vec[16:0]), 0);
    check_eq("R1", "cpu edges in power-down", cnt[0], 0);
    check_eq("R1", "shared pin edges in power-down", cnt[17] + cnt[18], 0);
  endtask

  task automatic t_release();
    pwr_dn = 1'b0;
    clear_counts();
    cyc(10);
    check_eq("R2", "cpu pulses after release", cnt[0], 8);
    check_eq("R2", "sdram pulses after release", cnt[11], 8);
    cyc(10);
    mon = 1'b1;
  endtask

  task automatic t_rates();
    clear_counts();
    cyc(40);
    for (int i = 0; i < 4; i++) check_eq("R3", "cpu rate", cnt[i], 40);
    for (int i = 11; i < 17; i++) check_eq("R3", "sdram rate", cnt[i], 40);
    for (int i = 4; i < 11; i++) check_eq("R4", "pci rate", cnt[i], 20);
    check_eq("R8", "shared pin 0 clock", cnt[17], 40);
    check_eq("R8", "shared pin 1 clock", cnt[18], 40);
  endtask

  task automatic t_cpu_stop();
    cpu_stop_drv = 1'b0;
    pci_stop_drv = 1'b0;
    mode = 1'b0;
    cyc(10);
    check_eq("R5", "pins float in mode low", int'(pins), 0);
    clear_counts();
    cpu_stop_drv = 1'b1;
    cyc(10);
    check_eq("R6", "cpu pulses after stop", cnt[0], 2);
    check_eq("R5", "pin 0 reads driven stop", int'(pins), 1);
    clear_counts();
    cyc(40);
    for (int i = 0; i < 4; i++) check_eq("R6", "cpu held low", cnt[i], 0);
    check_eq("R6", "pci keeps running", cnt[5], 20);
    check_eq("R6", "sdram keeps running", cnt[11], 40);
    clear_counts();
    cpu_stop_drv = 1'b0;
    cyc(10);
    check_eq("R6", "cpu pulses after unstop", cnt[0], 8);
  endtask

  task automatic t_pci_stop();
    pci_stop_drv = 1'b1;
    cyc(10);
    check_eq("R5", "pin 1 reads driven stop", int'(pins), 2);
    clear_counts();
    cyc(40);
    for (int i = 5; i < 11; i++) check_eq("R7", "gated pci low", cnt[i], 0);
    check_eq("R7", "free pci runs", cnt[4], 20);
    check_eq("R7", "cpu unaffected", cnt[0], 40);
    pci_stop_drv = 1'b0;
    cyc(10);
    phase_err = 0;
    clear_counts();
    cyc(40);
    check_eq("R7", "gated pci resumed", cnt[5], 20);
    check_eq("R10", "pci phase errors", phase_err, 0);
  endtask

  task automatic t_mode_high();
    cpu_stop_drv = 1'b1;
    pci_stop_drv = 1'b1;
    cyc(10);
    mode = 1'b1;
    cyc(10);
    clear_counts();
    cyc(40);
    check_eq("R8", "cpu runs in mode high", cnt[0], 40);
    check_eq("R8", "pci runs in mode high", cnt[6], 20);
    check_eq("R8", "pin 0 toggles", cnt[17], 40);
    check_eq("R8", "pin 1 toggles", cnt[18], 40);
    check_eq("R8", "sdram 5 toggles", cnt[16], 40);
  endtask

  task automatic t_async_pwr();
    @(posedge clk);
    #1;
    check_eq("R1", "cpu high before power-down", int'(cpu_clk[0]), 1);
    mon = 1'b0;
    pwr_dn = 1'b1;
    #1;
    check_eq("R1", "outputs low at once", int'(vec), 0);
    cyc(2);
    clear_counts();
    cyc(20);
    check_eq("R1", "no edges while down", cnt[0] + cnt[4] + cnt[11] + cnt[17], 0);
    pwr_dn = 1'b0;
    cyc(20);
    mon = 1'b1;
    clear_counts();
    cyc(20);
    check_eq("R2", "cpu runs after second release", cnt[3], 20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      check_eq("R9", "pulse width errors", width_err, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_release();
    t_rates();
    t_cpu_stop();
    t_pci_stop();
    t_mode_high();
    t_async_pwr();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end
endmodule